// File: doc/BRIEF.md
# SECDED Simple Dual-Port RAM

This block is a single-clock memory with a dedicated write port and a dedicated read port. Both ports have the same data width. On each write, an extended Hamming encoder appends check bits to the data word and stores the whole codeword in the array. On each read, the stored codeword is decoded. A single flipped bit is corrected on the read data output, and a two-bit corruption is reported as uncorrectable. Two status outputs report the outcome of each read and travel with the data they describe.

Correction is applied only on the read path. The array keeps whatever was stored, so a location with a single-bit fault reports that fault on every read until it is rewritten. Two test inputs corrupt the word being written, which lets the error paths be exercised through the normal ports. An optional register stage on the input side and another on the output side are selected by parameters. Each adds one cycle of read latency.

Top module: `secded_sdp_ram`

## Requirements
- R1: A write with both injection inputs low, followed by a read of that address, returns the written word with `sbit_err_o` and `dbit_err_o` both low. Each word is stored with CHK_W check bits. CHK_W is the number of Hamming parity bits plus one overall parity bit, with a minimum of 4. For 64 data bits, CHK_W is 8.
- R2: A word written with `inj_sbit_i` high has data bit 0 inverted in the array. Reading it returns the original data, with `sbit_err_o`=1 and `dbit_err_o`=0.
- R3: A word written with `inj_dbit_i` high has data bit 0 and the check bit at codeword position 1 inverted. Reading it gives `dbit_err_o`=1 and `sbit_err_o`=0. The data output carries the stored data bits uncorrected, which is the written word with bit 0 inverted. If both injection inputs are high, the double injection applies.
- R4: `sbit_err_o` and `dbit_err_o` are never high in the same cycle.
- R5: Correction is never written back. Reading a location with a single-bit fault a second time reports `sbit_err_o`=1 again.
- R6: Every write replaces the full data word and all of its check bits. A clean rewrite of a faulty location reads back with both flags low.
- R7: Read latency is 1 + IN_REG + OUT_REG clock cycles from `rd_addr_i`. Data and flags appear together in that cycle, and the previous result is held until then.
- R8: While `rst_ni` is low, `rd_data_o`, `sbit_err_o` and `dbit_err_o` are zero.
- R9: A read and a write to the same address in the same cycle return the contents held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of pipeline registers |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| inj_sbit_i | input | 1 | Corrupt one bit of the word being written |
| inj_dbit_i | input | 1 | Corrupt two bits of the word being written |
| rd_addr_i | input | ADDR_W | Read address, sampled every cycle |
| rd_data_o | output | DATA_W | Decoded (corrected) read data |
| sbit_err_o | output | 1 | Read word had a single-bit error, now corrected |
| dbit_err_o | output | 1 | Read word had an uncorrectable double-bit error |

## Verification
Read data and both flags are due exactly 1 + IN_REG + OUT_REG rising edges after the read address is presented. A write lands in the array 1 + IN_REG edges after it is driven. The bench derives the latency from the same two parameters it passes to the design, drives every input on a falling edge, and samples on the falling edge that follows the last register in the path. A back-to-back address change confirms that the old word is still present one cycle early and that the new word appears on time. The same-cycle collision case is counted the same way, because the write and read paths are delayed equally.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

  // Hamming parity bits for a data width (overall parity excluded); floor of 3
  function automatic int hamming_bits(int data_w);
    int r;
    r = 3;
    while ((1 << r) < data_w + r + 1) r++;
    return r;
  endfunction

  function automatic bit is_pow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc import secded_pkg::*; #(
  parameter int DATA_W = 64,
  localparam int HB    = hamming_bits(DATA_W),
  localparam int NPOS  = DATA_W + HB,
  localparam int CW_W  = NPOS + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  always_comb begin
    int  k;
    logic p;
    cw_o = '0;
    k    = 0;
    // data fills non power-of-two positions in ascending order
    for (int i = 1; i <= NPOS; i++) begin
      if (!is_pow2(i)) begin
        cw_o[i] = data_i[k];
        k++;
      end
    end
    for (int j = 0; j < HB; j++) begin
      p = 1'b0;
      for (int i = 1; i <= NPOS; i++) begin
        if (((i >> j) & 1) == 1) p = p ^ cw_o[i];
      end
      cw_o[1 << j] = p;
    end
    cw_o[0] = ^cw_o;
  end

endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec import secded_pkg::*; #(
  parameter int DATA_W = 64,
  localparam int HB    = hamming_bits(DATA_W),
  localparam int NPOS  = DATA_W + HB,
  localparam int CW_W  = NPOS + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbit_o,
  output logic              dbit_o
);

  logic [HB-1:0]   syn;
  logic            par_odd;
  logic [CW_W-1:0] cor;

  always_comb begin
    syn = '0;
    for (int j = 0; j < HB; j++) begin
      for (int i = 1; i <= NPOS; i++) begin
        if (((i >> j) & 1) == 1) syn[j] = syn[j] ^ cw_i[i];
      end
    end
    par_odd = ^cw_i;
  end

  always_comb begin
    int k;
    cor    = cw_i;
    sbit_o = 1'b0;
    dbit_o = 1'b0;
    if (syn != '0 && !par_odd) begin
      dbit_o = 1'b1;
    end else if (par_odd) begin
      if (int'(syn) > NPOS) begin
        dbit_o = 1'b1;  // syndrome points outside the word
      end else begin
        sbit_o = 1'b1;  // syn==0: overall parity bit itself flipped
        for (int i = 1; i <= NPOS; i++) begin
          if (int'(syn) == i) cor[i] = ~cor[i];
        end
      end
    end
    data_o = '0;
    k      = 0;
    for (int i = 1; i <= NPOS; i++) begin
      if (!is_pow2(i)) begin
        data_o[k] = cor[i];
        k++;
      end
    end
  end

  // R4
  dec_flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbit_o && dbit_o));

  // R1
  dec_clean_zero_syn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sbit_o && !dbit_o) |-> (syn == '0));

endmodule

// File: rtl/secded_array.sv
`timescale 1ns/1ps
module secded_array #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 72,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [WORD_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [WORD_W-1:0] rd_o
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [1:0]        warm_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // read-first: same-edge write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_o <= '0;
    else         rd_o <= mem[ra_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= '0;
    else         warm_q <= {warm_q[0], 1'b1};
  end

  // R5: with no intervening write the stored word never changes
  // R5
  no_writeback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !warm_q[1])
    ((ra_i == $past(ra_i)) && !($past(we_i) && ($past(wa_i) == ra_i))) |=> $stable(rd_o));

endmodule

// File: rtl/secded_sdp_ram.sv
`timescale 1ns/1ps
module secded_sdp_ram import secded_pkg::*; #(
  parameter int  DATA_W  = 64,
  parameter int  DEPTH   = 32,
  parameter bit  IN_REG  = 1'b1,
  parameter bit  OUT_REG = 1'b1,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int HB      = hamming_bits(DATA_W),
  localparam int CHK_W   = HB + 1,
  localparam int CW_W    = DATA_W + CHK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inj_sbit_i,
  input  logic              inj_dbit_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sbit_err_o,
  output logic              dbit_err_o
);

  localparam int FIRST_DATA_POS = 3;

  logic              we_s, inj_s_s, inj_d_s;
  logic [ADDR_W-1:0] wa_s, ra_s;
  logic [DATA_W-1:0] wd_s;
  logic [CW_W-1:0]   enc_cw, inj_mask, wr_cw, rd_cw;
  logic [DATA_W-1:0] dec_data;
  logic              dec_sbit, dec_dbit;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          we_s    <= 1'b0;
          wa_s    <= '0;
          wd_s    <= '0;
          inj_s_s <= 1'b0;
          inj_d_s <= 1'b0;
          ra_s    <= '0;
        end else begin
          we_s    <= wr_en_i;
          wa_s    <= wr_addr_i;
          wd_s    <= wr_data_i;
          inj_s_s <= inj_sbit_i;
          inj_d_s <= inj_dbit_i;
          ra_s    <= rd_addr_i;
        end
      end
    end else begin : g_in_bypass
      assign we_s    = wr_en_i;
      assign wa_s    = wr_addr_i;
      assign wd_s    = wr_data_i;
      assign inj_s_s = inj_sbit_i;
      assign inj_d_s = inj_dbit_i;
      assign ra_s    = rd_addr_i;
    end
  endgenerate

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data_i (wd_s),
    .cw_o   (enc_cw)
  );

  always_comb begin
    inj_mask = '0;
    if (inj_d_s) begin
      inj_mask[FIRST_DATA_POS] = 1'b1;
      inj_mask[1]              = 1'b1;
    end else if (inj_s_s) begin
      inj_mask[FIRST_DATA_POS] = 1'b1;
    end
  end

  assign wr_cw = enc_cw ^ inj_mask;

  secded_array #(.DEPTH(DEPTH), .WORD_W(CW_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_s),
    .wa_i   (wa_s),
    .wd_i   (wr_cw),
    .ra_i   (ra_s),
    .rd_o   (rd_cw)
  );

  secded_dec #(.DATA_W(DATA_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cw_i   (rd_cw),
    .data_o (dec_data),
    .sbit_o (dec_sbit),
    .dbit_o (dec_dbit)
  );

  generate
    if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rd_data_o  <= '0;
          sbit_err_o <= 1'b0;
          dbit_err_o <= 1'b0;
        end else begin
          rd_data_o  <= dec_data;
          sbit_err_o <= dec_sbit;
          dbit_err_o <= dec_dbit;
        end
      end
    end else begin : g_out_bypass
      assign rd_data_o  = dec_data;
      assign sbit_err_o = dec_sbit;
      assign dbit_err_o = dec_dbit;
    end
  endgenerate

  // R1
  enc_even_parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^enc_cw) == 1'b0);

  // R4
  out_flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sbit_err_o && dbit_err_o));

  // R3
  inj_double_two_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_d_s |-> ($countones(wr_cw ^ enc_cw) == 2));

endmodule

// File: tb/secded_sdp_ram_tb.sv
`timescale 1ns/1ps
module secded_sdp_ram_tb;

  localparam int DATA_W  = 64;
  localparam int DEPTH   = 32;
  localparam int ADDR_W  = 5;
  localparam bit IN_REG  = 1'b1;
  localparam bit OUT_REG = 1'b1;
  localparam int LAT     = 1 + int'(IN_REG) + int'(OUT_REG);
  localparam int NVEC    = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              inj_s;
    logic              inj_d;
    logic              exp_s;
    logic              exp_d;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{5'd0,  64'h0000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd1,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd2,  64'hA5A5_5A5A_A5A5_5A5A, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd3,  64'h0000_0000_0000_0000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{5'd4,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd5,  64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 1'b0, 1'b1},
    '{5'd31, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 1'b0, 1'b0},
    '{5'd6,  64'h8000_0000_0000_0001, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic              inj_sbit_i = 1'b0;
  logic              inj_dbit_i = 1'b0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              sbit_err_o;
  logic              dbit_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  secded_sdp_ram #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IN_REG(IN_REG), .OUT_REG(OUT_REG)
  ) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .inj_sbit_i (inj_sbit_i),
    .inj_dbit_i (inj_dbit_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .sbit_err_o (sbit_err_o),
    .dbit_err_o (dbit_err_o)
  );

  task automatic check(string req, logic [DATA_W-1:0] ed, logic es, logic edd);
    n_chk++;
    if (rd_data_o !== ed || sbit_err_o !== es || dbit_err_o !== edd) begin
      n_fail++;
      $display("FAIL %s: got data=%h s=%b d=%b, expected data=%h s=%b d=%b",
               req, rd_data_o, sbit_err_o, dbit_err_o, ed, es, edd);
    end
  endtask

  // called at a falling edge
  task automatic write_word(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic is, logic id);
    wr_en_i    = 1'b1;
    wr_addr_i  = a;
    wr_data_i  = d;
    inj_sbit_i = is;
    inj_dbit_i = id;
    @(negedge clk_i);
    wr_en_i    = 1'b0;
    inj_sbit_i = 1'b0;
    inj_dbit_i = 1'b0;
  endtask

  task automatic settle();
    repeat (LAT + 1) @(negedge clk_i);
  endtask

  task automatic read_check(string req, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] ed,
                            logic es, logic edd);
    rd_addr_i = a;
    repeat (LAT) @(posedge clk_i);
    @(negedge clk_i);
    check(req, ed, es, edd);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] ed;
    // R8: reset state
    repeat (3) @(negedge clk_i);
    check("R8", '0, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table-driven write then read (R1 R2 R3)
    for (int i = 0; i < NVEC; i++)
      write_word(VECS[i].addr, VECS[i].data, VECS[i].inj_s, VECS[i].inj_d);
    settle();
    for (int i = 0; i < NVEC; i++) begin
      ed = VECS[i].exp_d ? (VECS[i].data ^ 64'h1) : VECS[i].data;
      read_check(VECS[i].exp_d ? "R3" : (VECS[i].exp_s ? "R2" : "R1"),
                 VECS[i].addr, ed, VECS[i].exp_s, VECS[i].exp_d);
      // R4: flags never together
      n_chk++;
      if (sbit_err_o && dbit_err_o) begin
        n_fail++;
        $display("FAIL R4: got s=1 d=1, expected at most one flag");
      end
    end

    // R5: fault stays in array
    read_check("R5", 5'd2, 64'hA5A5_5A5A_A5A5_5A5A, 1'b1, 1'b0);
    read_check("R5", 5'd4, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1);

    // R6: clean rewrite clears the fault
    write_word(5'd2, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0, 1'b0);
    settle();
    read_check("R6", 5'd2, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0, 1'b0);

    // R7: exact latency
    write_word(5'd8, 64'h1111_1111_1111_1111, 1'b0, 1'b0);
    write_word(5'd9, 64'h2222_2222_2222_2222, 1'b0, 1'b0);
    settle();
    rd_addr_i = 5'd8;
    settle();
    rd_addr_i = 5'd9;
    repeat (LAT - 1) @(posedge clk_i);
    @(negedge clk_i);
    check("R7", 64'h1111_1111_1111_1111, 1'b0, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7", 64'h2222_2222_2222_2222, 1'b0, 1'b0);

    // R7: flags aligned with their word (faulty after clean)
    rd_addr_i = 5'd3;
    repeat (LAT - 1) @(posedge clk_i);
    @(negedge clk_i);
    check("R7", 64'h2222_2222_2222_2222, 1'b0, 1'b0);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7", 64'h0, 1'b1, 1'b0);

    // R9: same-cycle read and write return old contents
    rd_addr_i = 5'd1;
    settle();
    rd_addr_i = 5'd1;
    write_word(5'd1, 64'h5555_AAAA_5555_AAAA, 1'b0, 1'b0);
    repeat (LAT - 1) @(posedge clk_i);
    @(negedge clk_i);
    check("R9", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    @(negedge clk_i);
    read_check("R9", 5'd1, 64'h5555_AAAA_5555_AAAA, 1'b0, 1'b0);

    // R3: both injections on an all-ones word at the top address
    write_word(5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
    settle();
    read_check("R3", 5'd31, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1);

    // R8: reset in mid-run clears outputs
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8", '0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end

endmodule